// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block keeps a 64-bit signed running total split across two 32-bit words: an upper word and a lower word. On each accumulate strobe it multiplies two operands as signed numbers and adds the product to the total. In the long form the full 32-bit operands are multiplied. In the short form only the low 16 bits of each operand are used, each sign-extended. A saturation enable selects how an overflowing total is folded back into the two words. The long form and the short form have different folding rules. In the short form an overflow leaves a flag value of one in the upper word.

Software or a sequencer can also zero the total or load either word directly. Each cycle a priority decoder picks one operation: OP_CLEAR, OP_LOAD, OP_ACC_LONG, OP_ACC_WORD or OP_HOLD. The accumulator register then takes the value that the output process computes for that operation. The register changes state on every rising edge: OP_CLEAR moves it to zero, OP_LOAD replaces the selected words, the two OP_ACC operations move it to the folded sum, and OP_HOLD leaves it unchanged.

Top module: `mac_sat_unit`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) makes both acc_hi and acc_lo zero.
- R2: clr high zeroes both words at the next edge, whatever the write enables and acc_go are doing (OP_CLEAR has the highest priority).
- R3: With clr low, hi_we loads hi_wdata into acc_hi and lo_we loads lo_wdata into acc_lo (OP_LOAD). A word whose enable is low keeps its value. Any write enable suppresses accumulation in that cycle.
- R4: In long mode (word_mode=0) with sat_en=0, an accumulate adds opa*opb, taken as signed 32-bit numbers, to the signed 64-bit {acc_hi, acc_lo}. The sum wraps modulo 2^64 and is split unchanged: bits 63..32 go to acc_hi and bits 31..0 go to acc_lo.
- R5: In word mode (word_mode=1), the product is the signed 16-bit opa[15:0] times the signed 16-bit opb[15:0]. Bits 31..16 of both operands have no effect.
- R6: In long mode with sat_en=1, when the 64-bit sum is negative, acc_hi bits 31..16 are set to one and all other bits of the sum are kept.
- R7: In long mode with sat_en=1, when the sum is zero or positive, acc_hi bits 31..15 are cleared and acc_hi bits 14..0 and acc_lo are kept.
- R8: In word mode with sat_en=1, a sum below -2^31 stores acc_lo=0x80000000 and acc_hi=0x00000001.
- R9: In word mode with sat_en=1, a sum above 2^31-1 stores acc_lo=0x7FFFFFFF and acc_hi=0x00000001.
- R10: In word mode with sat_en=1, a sum in [-2^31, 2^31-1] is stored as the plain 64-bit split.
- R11: With clr, hi_we, lo_we and acc_go all low, both words hold (OP_HOLD).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opa | input | 32 | First multiplier operand |
| opb | input | 32 | Second multiplier operand |
| word_mode | input | 1 | 1: 16x16 product, 0: 32x32 product |
| sat_en | input | 1 | Saturation enable |
| acc_go | input | 1 | Accumulate strobe |
| clr | input | 1 | Clear strobe |
| hi_we | input | 1 | Write enable for the upper word |
| hi_wdata | input | 32 | Write data for the upper word |
| lo_we | input | 1 | Write enable for the lower word |
| lo_wdata | input | 32 | Write data for the lower word |
| acc_hi | output | 32 | Upper accumulator word |
| acc_lo | output | 32 | Lower accumulator word |

## Verification
Directed vectors preload the words and then accumulate a small product, so that the folded total lands exactly on each side of every saturation limit. This separates the negative and non-negative long-mode rules and the below-range, above-range and in-range word-mode cases. Word-mode operands carry garbage in their upper halves, so a multiplier that reads those bits gives a different total. Strobes that collide in one cycle test the priority order. A long run of random mixed operations, compared every cycle against a behavioural 64-bit model, covers carries across the word boundary and modulo-2^64 wrap.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [2:0] {
        OP_HOLD     = 3'd0,
        OP_CLEAR    = 3'd1,
        OP_LOAD     = 3'd2,
        OP_ACC_LONG = 3'd3,
        OP_ACC_WORD = 3'd4
    } mac_op_e;

endpackage

// File: rtl/mac_op_decode.sv
module mac_op_decode
    import mac_pkg::*;
(
    input  logic    clr,
    input  logic    hi_we,
    input  logic    lo_we,
    input  logic    acc_go,
    input  logic    word_mode,
    output mac_op_e op
);

    // Fixed priority: clear, then any write, then accumulate.
    always_comb begin
        if (clr) begin
            op = OP_CLEAR;
        end else if (hi_we || lo_we) begin
            op = OP_LOAD;
        end else if (acc_go) begin
            op = word_mode ? OP_ACC_WORD : OP_ACC_LONG;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/mac_product.sv
module mac_product #(
    parameter int DW = 32
) (
    input  logic [DW-1:0]          opa,
    input  logic [DW-1:0]          opb,
    input  logic                   word_mode,
    output logic signed [2*DW-1:0] prod
);

    localparam int HW = DW / 2;
    localparam int AW = 2 * DW;

    logic signed [DW-1:0] full_a, full_b;
    logic signed [HW-1:0] half_a, half_b;
    logic signed [AW-1:0] prod_long, prod_word;

    assign full_a = opa;
    assign full_b = opb;
    assign half_a = opa[HW-1:0];
    assign half_b = opb[HW-1:0];

    // Operands are sign-extended to the accumulator width before multiplying.
    assign prod_long = AW'(full_a) * AW'(full_b);
    assign prod_word = AW'(half_a) * AW'(half_b);

    assign prod = word_mode ? prod_word : prod_long;

endmodule

// File: rtl/mac_saturate.sv
module mac_saturate #(
    parameter int DW = 32
) (
    input  logic [2*DW-1:0] sum,
    input  logic            word_mode,
    input  logic            sat_en,
    output logic [DW-1:0]   hi_out,
    output logic [DW-1:0]   lo_out
);

    localparam int HW = DW / 2;
    localparam int AW = 2 * DW;
    localparam logic [DW-1:0] HI_NEG_FILL = {{HW{1'b1}}, {HW{1'b0}}};
    localparam logic [DW-1:0] HI_POS_KEEP = {{(HW+1){1'b0}}, {(HW-1){1'b1}}};
    localparam logic [DW-1:0] LO_MIN      = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] LO_MAX      = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] HI_FLAG     = DW'(1);

    logic            neg;
    logic            fits;
    logic [DW:0]     top_bits;

    assign neg      = sum[AW-1];
    assign top_bits = sum[AW-1:DW-1];
    // The sum fits a signed DW-bit word when all bits from DW-1 up agree.
    assign fits     = (top_bits == '0) || (top_bits == '1);

    always_comb begin
        hi_out = sum[AW-1:DW];
        lo_out = sum[DW-1:0];
        if (sat_en) begin
            if (!word_mode) begin
                if (neg) hi_out = sum[AW-1:DW] | HI_NEG_FILL;
                else     hi_out = sum[AW-1:DW] & HI_POS_KEEP;
            end else if (!fits) begin
                hi_out = HI_FLAG;
                lo_out = neg ? LO_MIN : LO_MAX;
            end
        end
    end

endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit
    import mac_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic          word_mode,
    input  logic          sat_en,
    input  logic          acc_go,
    input  logic          clr,
    input  logic          hi_we,
    input  logic [DW-1:0] hi_wdata,
    input  logic          lo_we,
    input  logic [DW-1:0] lo_wdata,
    output logic [DW-1:0] acc_hi,
    output logic [DW-1:0] acc_lo
);

    localparam int AW = 2 * DW;

    mac_op_e               op;
    logic signed [AW-1:0]  prod;
    logic [AW-1:0]         sum;
    logic [DW-1:0]         sat_hi, sat_lo;
    logic [DW-1:0]         hi_q, lo_q, hi_d, lo_d;

    mac_op_decode u_dec (
        .clr       (clr),
        .hi_we     (hi_we),
        .lo_we     (lo_we),
        .acc_go    (acc_go),
        .word_mode (word_mode),
        .op        (op)
    );

    mac_product #(.DW(DW)) u_mul (
        .opa       (opa),
        .opb       (opb),
        .word_mode (word_mode),
        .prod      (prod)
    );

    assign sum = {hi_q, lo_q} + prod;

    mac_saturate #(.DW(DW)) u_sat (
        .sum       (sum),
        .word_mode (word_mode),
        .sat_en    (sat_en),
        .hi_out    (sat_hi),
        .lo_out    (sat_lo)
    );

    // Next-value process: one arm per operation.
    always_comb begin
        hi_d = hi_q;
        lo_d = lo_q;
        unique case (op)
            OP_CLEAR: begin
                hi_d = '0;
                lo_d = '0;
            end
            OP_LOAD: begin
                if (hi_we) hi_d = hi_wdata;
                if (lo_we) lo_d = lo_wdata;
            end
            OP_ACC_LONG, OP_ACC_WORD: begin
                hi_d = sat_hi;
                lo_d = sat_lo;
            end
            OP_HOLD: begin
                hi_d = hi_q;
                lo_d = lo_q;
            end
            default: begin
                hi_d = hi_q;
                lo_d = lo_q;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            hi_q <= hi_d;
            lo_q <= lo_d;
        end
    end

    assign acc_hi = hi_q;
    assign acc_lo = lo_q;

endmodule

// File: rtl/mac_sat_unit_chk.sv
module mac_sat_unit_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          word_mode,
    input logic          sat_en,
    input logic          acc_go,
    input logic          clr,
    input logic          hi_we,
    input logic [DW-1:0] hi_wdata,
    input logic          lo_we,
    input logic [DW-1:0] lo_wdata,
    input logic [DW-1:0] acc_hi,
    input logic [DW-1:0] acc_lo
);

    localparam int HW = DW / 2;

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc_hi == '0 && acc_lo == '0)); // R2

    AST_HI_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!clr && hi_we) |=> (acc_hi == $past(hi_wdata))); // R3

    AST_LO_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!clr && lo_we) |=> (acc_lo == $past(lo_wdata))); // R3

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!clr && !hi_we && !lo_we && !acc_go) |=> ($stable(acc_hi) && $stable(acc_lo))); // R11

    AST_LONG_SAT_SHAPE: assert property (@(posedge clk) disable iff (rst)
        (!clr && !hi_we && !lo_we && acc_go && !word_mode && sat_en)
        |=> (acc_hi[DW-1:HW] == '1 || acc_hi[DW-1:HW-1] == '0)); // R6 R7

endmodule

bind mac_sat_unit mac_sat_unit_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .word_mode (word_mode),
    .sat_en    (sat_en),
    .acc_go    (acc_go),
    .clr       (clr),
    .hi_we     (hi_we),
    .hi_wdata  (hi_wdata),
    .lo_we     (lo_we),
    .lo_wdata  (lo_wdata),
    .acc_hi    (acc_hi),
    .acc_lo    (acc_lo)
);

// File: tb/mac_sat_unit_tb.sv
`timescale 1ns/1ps
module mac_sat_unit_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] opa, opb, hi_wdata, lo_wdata;
    logic        word_mode, sat_en, acc_go, clr, hi_we, lo_we;
    logic [31:0] acc_hi, acc_lo;

    int   n_vec  = 0;
    int   n_bad  = 0;
    bit   done   = 1'b0;
    logic [63:0] m_acc;

    always #2.5 clk = ~clk;

    mac_sat_unit u_dut (
        .clk(clk), .rst(rst), .opa(opa), .opb(opb),
        .word_mode(word_mode), .sat_en(sat_en), .acc_go(acc_go), .clr(clr),
        .hi_we(hi_we), .hi_wdata(hi_wdata), .lo_we(lo_we), .lo_wdata(lo_wdata),
        .acc_hi(acc_hi), .acc_lo(acc_lo)
    );

    task automatic compare(string req);
        n_vec++;
        if (acc_hi !== m_acc[63:32] || acc_lo !== m_acc[31:0]) begin
            n_bad++;
            $display("FAIL %s: got %h_%h expected %h_%h", req, acc_hi, acc_lo,
                     m_acc[63:32], m_acc[31:0]);
        end
    endtask

    // Behavioural reference step for one clock.
    task automatic model(logic c, logic hw, logic [31:0] hd, logic lw, logic [31:0] ld,
                         logic go, logic wm, logic s, logic [31:0] a, logic [31:0] b);
        longint p, sum;
        logic [31:0] h, l;
        if (c) begin
            m_acc = 64'd0;
        end else if (hw || lw) begin
            if (hw) m_acc[63:32] = hd;
            if (lw) m_acc[31:0]  = ld;
        end else if (go) begin
            if (wm) p = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
            else    p = longint'($signed(a)) * longint'($signed(b));
            sum = longint'(m_acc) + p;
            h = sum[63:32];
            l = sum[31:0];
            if (s && !wm) begin
                if (sum < 0) h = h | 32'hFFFF_0000;
                else         h = h & 32'h0000_7FFF;
            end else if (s && wm) begin
                if (sum < -64'sd2147483648) begin h = 32'd1; l = 32'h8000_0000; end
                else if (sum > 64'sd2147483647) begin h = 32'd1; l = 32'h7FFF_FFFF; end
            end
            m_acc = {h, l};
        end
    endtask

    task automatic step(string req, logic c, logic hw, logic [31:0] hd, logic lw,
                        logic [31:0] ld, logic go, logic wm, logic s,
                        logic [31:0] a, logic [31:0] b);
        @(negedge clk);
        clr = c; hi_we = hw; hi_wdata = hd; lo_we = lw; lo_wdata = ld;
        acc_go = go; word_mode = wm; sat_en = s; opa = a; opb = b;
        @(posedge clk);
        model(c, hw, hd, lw, ld, go, wm, s, a, b);
        #1;
        compare(req);
    endtask

    task automatic load(string req, logic [31:0] h, logic [31:0] l);
        step(req, 0, 1, h, 1, l, 0, 0, 0, 0, 0);
    endtask

    initial begin
        rst = 1'b1; clr = 0; hi_we = 0; lo_we = 0; acc_go = 0;
        word_mode = 0; sat_en = 0; opa = 0; opb = 0; hi_wdata = 0; lo_wdata = 0;
        m_acc = 64'd0;
        repeat (2) @(posedge clk);
        #1; compare("R1 reset");
        @(negedge clk); rst = 1'b0;

        // R4 long accumulate, plain split
        step("R4", 0,0,0,0,0, 1,0,0, 32'd3, 32'd5);
        step("R4", 0,0,0,0,0, 1,0,0, 32'hFFFF_FFFF, 32'd7);
        step("R4", 0,0,0,0,0, 1,0,0, 32'h8000_0000, 32'h8000_0000);
        load("R3", 32'hFFFF_FFFF, 32'hFFFF_FFF0);
        step("R4 wrap", 0,0,0,0,0, 1,0,0, 32'd4, 32'd5);
        // R11 idle
        step("R11", 0,0,32'h1111,0,32'h2222, 0,1,1, 32'd9, 32'd9);
        // R5 upper operand bits ignored in word mode
        step("R2", 1,0,0,0,0, 0,0,0, 0, 0);
        step("R5", 0,0,0,0,0, 1,1,0, 32'hABCD_8000, 32'h1234_0002);
        step("R5", 0,0,0,0,0, 1,1,0, 32'h5555_7FFF, 32'hAAAA_FFFF);
        // R3 write suppresses accumulate, single half
        step("R3", 0,1,32'hDEAD_BEEF,0,32'h0, 1,0,0, 32'd100, 32'd100);
        step("R3", 0,0,32'h0,1,32'hCAFE_F00D, 1,1,1, 32'd100, 32'd100);
        // R2 clear beats everything
        step("R2", 1,1,32'h1,1,32'h2, 1,0,0, 32'd7, 32'd7);
        // R7 non-negative long saturate
        load("R3", 32'h0000_1234, 32'h0);
        step("R7", 0,0,0,0,0, 1,0,1, 32'hFFFF_FFFF, 32'd1);
        load("R3", 32'h0001_8000, 32'h0);
        step("R7", 0,0,0,0,0, 1,0,1, 32'd0, 32'd5);
        // R6 negative long saturate
        load("R3", 32'h8000_0005, 32'h0);
        step("R6", 0,0,0,0,0, 1,0,1, 32'd0, 32'd0);
        step("R2", 1,0,0,0,0, 0,0,0, 0, 0);
        step("R6", 0,0,0,0,0, 1,0,1, 32'hFFFF_FFFF, 32'd3);
        // R8 below range in word mode
        load("R3", 32'hFFFF_FFFF, 32'h8000_0000);
        step("R8", 0,0,0,0,0, 1,1,1, 32'hFFFF_FFFF, 32'd1);
        // R9 above range in word mode
        load("R3", 32'h0, 32'h7FFF_FFFF);
        step("R9", 0,0,0,0,0, 1,1,1, 32'd1, 32'd1);
        // R10 in range and exact limits
        step("R2", 1,0,0,0,0, 0,0,0, 0, 0);
        step("R10", 0,0,0,0,0, 1,1,1, 32'h0000_7FFF, 32'h0000_7FFF);
        load("R3", 32'h0, 32'h7FFF_FFFE);
        step("R10", 0,0,0,0,0, 1,1,1, 32'd1, 32'd1);
        load("R3", 32'hFFFF_FFFF, 32'h8000_0001);
        step("R10", 0,0,0,0,0, 1,1,1, 32'hFFFF_FFFF, 32'd1);

        // Random mixed operations
        for (int i = 0; i < 400; i++) begin
            logic [3:0] r;
            r = 4'($urandom);
            step("R4 R5 R6 R7 R8 R9 R10 random",
                 (r == 4'd0), (r == 4'd1), $urandom, (r == 4'd2), $urandom,
                 1'($urandom), 1'($urandom), 1'($urandom), $urandom, $urandom);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule